// File: doc/BRIEF.md
# Character Display Parallel Bus Engine

This block runs single register accesses on the parallel bus of a character display from the host side. The bus has a register-select line, a direction line, an enable strobe and an eight-bit data bus. The output and input halves of the data bus are kept as separate ports, with an output-enable. An internal client asks for one access at a time on a valid/ready port. Each request carries register select, direction and a write byte. The engine drives the select and direction lines, then strobes enable. It holds every bus timing minimum, and returns the captured byte together with a one-cycle done pulse.

Every timing minimum is a nanosecond parameter and is converted into whole clock counts, rounded up. A byte can go out as one full eight-bit transfer. It can also go out as two four-bit transfers on the upper four data lanes, high nibble first. The lane mode is taken from an input at the moment a request is accepted. What commands mean, how the display's busy state is polled and the order of power-up commands are left to the client.

Top module: `lcdbus_engine`

## Requirements
- R1: During and after synchronous active-low reset, enable, output-enable and the direction line are low, req_ready is high and done is low.
- R2: Register select and the direction line hold the same value for at least ceil(T_AS_NS/CLK_NS) clock cycles (10 with defaults) before enable rises.
- R3: Enable stays high for at least ceil(T_PW_NS/CLK_NS) clock cycles (30 with defaults). This is raised, if needed, so that the read sample edge is at least ceil(T_RDV_NS/CLK_NS) cycles (9) after enable rises.
- R4: Two consecutive rising edges of enable are at least ceil(T_CYC_NS/CLK_NS) cycles apart (50 with defaults). This also holds across back-to-back requests.
- R5: Register select, the direction line, the output-enable and the driven data do not change in the cycle in which enable falls. They are held for ceil(max(T_AH_NS,T_DH_NS)/CLK_NS) cycles.
- R6: A write (req_rd=0) drives the direction line low and output-enable high for the whole transfer. In eight-bit mode lcd_db_out equals the write byte.
- R7: A read (req_rd=1) drives the direction line high. Output-enable is never high while the direction line is high. The byte on lcd_db_in is captured on the last clock of the enable-high phase and is returned on done_rdata.
- R8: In four-bit mode (mode4=1) a byte takes two enable pulses. The first carries bits 7..4 on lanes 7..4 and the second carries bits 3..0 on lanes 7..4, with lanes 3..0 driven to zero. On a read, lanes 7..4 of the first pulse become bits 7..4 of the result, lanes 7..4 of the second pulse become bits 3..0, and lanes 3..0 are ignored.
- R9: req_ready is high only while no access is in flight, and a request is accepted on a clock where req_valid and req_ready are both high. After the final hold phase ends, done pulses for one cycle while req_ready is high, and a waiting request is accepted on that same cycle.
- R10: mode4 is sampled only when a request is accepted. Changing it while an access is in flight has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode4 | input | 1 | 1 selects nibble-pair transfers on lanes 7..4, sampled at acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle and able to accept |
| req_rs | input | 1 | Register select value for the access |
| req_rd | input | 1 | 1 for read, 0 for write |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle pulse at the end of an access |
| done_rdata | output | 8 | Byte captured by the last read |
| lcd_rs | output | 1 | Bus register select |
| lcd_rw | output | 1 | Bus direction, 1 = display drives |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_db_out | output | 8 | Data driven towards the display |
| lcd_db_oe | output | 1 | Output-enable for lcd_db_out |
| lcd_db_in | input | 8 | Data returned by the display |

## Verification
The completion of one access and the acceptance of the next share a clock. The done pulse and req_ready rise together, and a request already waiting is taken on that same edge. The bench provokes this by presenting each new request while the previous one is still in flight and holding req_valid until it is taken. It then judges the overlap in two ways. The returned byte and pulse count must belong to the finished access, not the new one. The next enable rise must still respect the rise-to-rise minimum, even though the setup phase of the new access starts immediately. The mode input is also flipped right after each acceptance, so any late sampling shows up as a wrong pulse count.

// File: rtl/lcdbus_pkg.sv
// Package: shared phase encoding and timing arithmetic for the display bus engine.
// Assumes all timing inputs are positive nanosecond values.
package lcdbus_pkg;

    localparam int DB_W  = 8;
    localparam int NIB_W = 4;

    // Bus phase of the engine, one per segment of an enable cycle.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HIGH  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    // Nanoseconds to clock cycles, rounded up, never below one.
    function automatic int ns_to_clk(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcdbus_timer.sv
// Module: loadable down-counter that reports when a programmed count has run out.
// Assumes load_val = N-1 gives exactly N cycles until expired is seen in the owning state.
module lcdbus_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // Count down towards zero, restarting on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcdbus_datapath.sv
// Module: holds the write byte, steers bytes or nibbles onto the bus lanes and
// assembles the read byte. Assumes the sequencer gives "second" = 0 for the high
// nibble and 1 for the low nibble, and a single-cycle capture strobe per transfer.
module lcdbus_datapath
    import lcdbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [DB_W-1:0] wbyte_in,
    input  logic            mode4_in,
    input  logic            second,
    input  logic            capture,
    input  logic [DB_W-1:0] db_in,
    output logic [DB_W-1:0] db_word,
    output logic [DB_W-1:0] rbyte,
    output logic            mode4_q
);

    logic [DB_W-1:0]  wbyte_q;
    logic [DB_W-1:0]  rbyte_q;
    logic [NIB_W-1:0] wnib;

    // Latch the write byte and lane mode when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbyte_q <= '0;
            mode4_q <= 1'b0;
        end else if (accept) begin
            wbyte_q <= wbyte_in;
            mode4_q <= mode4_in;
        end
    end

    // Pick the nibble for the current half of a four-bit transfer.
    assign wnib = second ? wbyte_q[NIB_W-1:0] : wbyte_q[DB_W-1:NIB_W];

    // Lane steering: full byte, or nibble on the upper lanes with lower lanes at zero.
    always_comb begin
        if (mode4_q) begin
            db_word = {wnib, {(DB_W-NIB_W){1'b0}}};
        end else begin
            db_word = wbyte_q;
        end
    end

    // Capture returned data into the right part of the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbyte_q <= '0;
        end else if (capture) begin
            if (!mode4_q) begin
                rbyte_q <= db_in;
            end else if (second) begin
                rbyte_q[NIB_W-1:0] <= db_in[DB_W-1:NIB_W];
            end else begin
                rbyte_q[DB_W-1:NIB_W] <= db_in[DB_W-1:NIB_W];
            end
        end
    end

    assign rbyte = rbyte_q;

endmodule

// File: rtl/lcdbus_fsm.sv
// Module: sequences setup, enable-high and hold phases for each transfer, repeats
// once for the low nibble in four-bit mode and gates every enable rise on the
// cycle guard. Assumes phase counts are at least one cycle each.
module lcdbus_fsm
    import lcdbus_pkg::*;
#(
    parameter int TW    = 6,
    parameter int C_AS  = 10,
    parameter int C_HI  = 30,
    parameter int C_HLD = 1,
    parameter int C_CYC = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_rs,
    input  logic          req_rd,
    input  logic          mode4_q,
    input  logic          ph_exp,
    input  logic          gd_exp,
    output phase_e        phase,
    output logic          ph_load,
    output logic [TW-1:0] ph_val,
    output logic          gd_load,
    output logic [TW-1:0] gd_val,
    output logic          accept,
    output logic          second,
    output logic          capture,
    output logic          done,
    output logic          rs_q,
    output logic          rd_q
);

    phase_e phase_q;
    phase_e phase_d;
    logic   second_q;
    logic   done_q;
    logic   last_xfer;

    assign last_xfer = !mode4_q || second_q;
    assign gd_val    = TW'(C_CYC - 1);

    // Next-phase decision and timer loads.
    always_comb begin
        phase_d = phase_q;
        ph_load = 1'b0;
        ph_val  = '0;
        gd_load = 1'b0;
        accept  = 1'b0;
        capture = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    phase_d = PH_SETUP;
                    ph_load = 1'b1;
                    ph_val  = TW'(C_AS - 1);
                end
            end
            PH_SETUP: begin
                if (ph_exp && gd_exp) begin
                    phase_d = PH_HIGH;
                    ph_load = 1'b1;
                    ph_val  = TW'(C_HI - 1);
                    gd_load = 1'b1;
                end
            end
            PH_HIGH: begin
                if (ph_exp) begin
                    phase_d = PH_HOLD;
                    ph_load = 1'b1;
                    ph_val  = TW'(C_HLD - 1);
                    capture = rd_q;
                end
            end
            PH_HOLD: begin
                if (ph_exp) begin
                    if (last_xfer) begin
                        phase_d = PH_IDLE;
                    end else begin
                        phase_d = PH_SETUP;
                        ph_load = 1'b1;
                        ph_val  = TW'(C_AS - 1);
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Nibble half tracker: cleared on accept, set after the first half's hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q <= 1'b0;
        end else if (accept) begin
            second_q <= 1'b0;
        end else if (phase_q == PH_HOLD && ph_exp && !last_xfer) begin
            second_q <= 1'b1;
        end
    end

    // Completion pulse raised in the first idle cycle after the final hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_HOLD) && ph_exp && last_xfer;
        end
    end

    // Request attributes held for the life of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= 1'b0;
            rd_q <= 1'b0;
        end else if (accept) begin
            rs_q <= req_rs;
            rd_q <= req_rd;
        end
    end

    assign phase  = phase_q;
    assign second = second_q;
    assign done   = done_q;

endmodule

// File: rtl/lcdbus_engine.sv
// Module: top of the display bus engine. Converts nanosecond minimums to clock
// counts, ties sequencer, timers and datapath together and decodes the bus pins
// from the phase. Assumes CLK_NS is the system clock period in nanoseconds.
module lcdbus_engine
    import lcdbus_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int T_AS_NS   = 100,
    parameter int T_PW_NS   = 300,
    parameter int T_CYC_NS  = 500,
    parameter int T_AH_NS   = 10,
    parameter int T_DH_NS   = 10,
    parameter int T_DSW_NS  = 60,
    parameter int T_RDV_NS  = 90
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode4,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic       req_rd,
    input  logic [7:0] req_wdata,
    output logic       done,
    output logic [7:0] done_rdata,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    input  logic [7:0] lcd_db_in
);

    localparam int C_AS   = ns_to_clk(T_AS_NS, CLK_NS);
    localparam int C_PW   = ns_to_clk(T_PW_NS, CLK_NS);
    localparam int C_CYC  = ns_to_clk(T_CYC_NS, CLK_NS);
    localparam int C_HLD  = imax(ns_to_clk(T_AH_NS, CLK_NS), ns_to_clk(T_DH_NS, CLK_NS));
    localparam int C_RDV  = ns_to_clk(T_RDV_NS, CLK_NS);
    localparam int C_DSW  = ns_to_clk(T_DSW_NS, CLK_NS);
    // High phase long enough for width, read-valid delay and write data setup.
    localparam int C_HI   = imax(imax(C_PW, C_RDV), C_DSW);
    localparam int C_MAX  = imax(imax(C_AS, C_HI), imax(C_HLD, C_CYC));
    localparam int TW     = $clog2(C_MAX + 1);

    phase_e          phase;
    logic            ph_load, gd_load, ph_exp, gd_exp;
    logic [TW-1:0]   ph_val, gd_val;
    logic            accept, second, capture, rs_q, rd_q, mode4_q;
    logic [DB_W-1:0] db_word;
    logic            busy;

    lcdbus_fsm #(
        .TW(TW), .C_AS(C_AS), .C_HI(C_HI), .C_HLD(C_HLD), .C_CYC(C_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_rs(req_rs), .req_rd(req_rd),
        .mode4_q(mode4_q), .ph_exp(ph_exp), .gd_exp(gd_exp),
        .phase(phase), .ph_load(ph_load), .ph_val(ph_val),
        .gd_load(gd_load), .gd_val(gd_val),
        .accept(accept), .second(second), .capture(capture), .done(done),
        .rs_q(rs_q), .rd_q(rd_q)
    );

    // Phase length timer: setup, high and hold durations.
    lcdbus_timer #(.TW(TW)) u_phase_tmr (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_exp)
    );

    // Cycle guard: minimum spacing between enable rises.
    lcdbus_timer #(.TW(TW)) u_guard_tmr (
        .clk(clk), .rst_n(rst_n), .load(gd_load), .load_val(gd_val), .expired(gd_exp)
    );

    lcdbus_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .wbyte_in(req_wdata), .mode4_in(mode4),
        .second(second), .capture(capture), .db_in(lcd_db_in),
        .db_word(db_word), .rbyte(done_rdata), .mode4_q(mode4_q)
    );

    // Bus pin decode from the registered phase.
    assign busy       = (phase != PH_IDLE);
    assign req_ready  = !busy;
    assign lcd_e      = (phase == PH_HIGH);
    assign lcd_rs     = rs_q;
    assign lcd_rw     = busy && rd_q;
    assign lcd_db_oe  = busy && !rd_q;
    assign lcd_db_out = lcd_db_oe ? db_word : '0;

endmodule

// File: rtl/lcdbus_engine_chk.sv
// Module: protocol checker for the display bus engine, attached by bind.
// Assumes the counts passed in match those used by the engine.
module lcdbus_engine_chk #(
    parameter int C_AS  = 10,
    parameter int C_PW  = 30,
    parameter int C_CYC = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lcd_e,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_db_oe,
    input logic [7:0] lcd_db_out,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done
);

    logic       e_q, rs_q, rw_q, oe_q, seen_rise;
    logic [7:0] db_q;
    int         ctl_age, hi_len, rise_gap;

    // History of bus pins and the window counters used by the properties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q       <= 1'b0;
            rs_q      <= 1'b0;
            rw_q      <= 1'b0;
            oe_q      <= 1'b0;
            db_q      <= '0;
            ctl_age   <= 0;
            hi_len    <= 0;
            rise_gap  <= 0;
            seen_rise <= 1'b0;
        end else begin
            e_q  <= lcd_e;
            rs_q <= lcd_rs;
            rw_q <= lcd_rw;
            oe_q <= lcd_db_oe;
            db_q <= lcd_db_out;
            if ((lcd_rs != rs_q) || (lcd_rw != rw_q)) ctl_age <= 0;
            else if (ctl_age < 100000)                ctl_age <= ctl_age + 1;
            hi_len <= lcd_e ? hi_len + 1 : 0;
            if (lcd_e && !e_q) begin
                rise_gap  <= 1;
                seen_rise <= 1'b1;
            end else if (rise_gap < 100000) begin
                rise_gap <= rise_gap + 1;
            end
        end
    end

    a_r2_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !e_q) |-> (ctl_age >= C_AS - 1) && (lcd_rs == rs_q) && (lcd_rw == rw_q));

    a_r3_enable_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_e && e_q) |-> (hi_len >= C_PW));

    a_r4_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !e_q && seen_rise) |-> (rise_gap >= C_CYC));

    a_r5_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_e && e_q) |-> (lcd_rs == rs_q) && (lcd_rw == rw_q)
                            && (lcd_db_oe == oe_q) && (lcd_db_out == db_q));

    a_r7_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rw |-> !lcd_db_oe);

    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    a_r9_single_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind lcdbus_engine lcdbus_engine_chk #(
    .C_AS(C_AS), .C_PW(C_PW), .C_CYC(C_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_db_oe(lcd_db_oe), .lcd_db_out(lcd_db_out),
    .req_valid(req_valid), .req_ready(req_ready), .done(done)
);

// File: tb/sim_lcdbus_engine.sv
// Bench: scoreboard of expected accesses fed by a driver task, a monitor that
// models the display and compares bus pins and results at each negative edge.
module sim_lcdbus_engine;

    localparam int CLK_PERIOD = 10;
    localparam int EXP_AS  = 10;
    localparam int EXP_PW  = 30;
    localparam int EXP_CYC = 50;
    localparam int EXP_RDV = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode4 = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_rs = 1'b0;
    logic       req_rd = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       done;
    logic [7:0] done_rdata;
    logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [7:0] lcd_db_out;
    logic [7:0] lcd_db_in = 8'h3C;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdbus_engine u0 (
        .clk(clk), .rst_n(rst_n), .mode4(mode4),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_rs(req_rs), .req_rd(req_rd), .req_wdata(req_wdata),
        .done(done), .done_rdata(done_rdata),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
        .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
    );

    typedef struct packed {
        logic       rs;
        logic       rd;
        logic       m4;
        logic [7:0] wb;
        logic [7:0] rb;
    } item_t;

    item_t exp_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    ended  = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Driver: queue the expectation, present the request, flip mode4 once taken.
    task automatic send(input logic rs, input logic rd, input logic m4,
                        input logic [7:0] wb, input logic [7:0] rb);
        item_t it;
        it = '{rs: rs, rd: rd, m4: m4, wb: wb, rb: rb};
        @(negedge clk);
        exp_q.push_back(it);
        req_valid = 1'b1;
        req_rs    = rs;
        req_rd    = rd;
        req_wdata = wb;
        mode4     = m4;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = 8'h00;
        mode4     = !m4;   // R10: late change must not matter
    endtask

    logic       e_prev = 1'b0, prs = 1'b0, prw = 1'b0, poe = 1'b0;
    logic [7:0] pdb = '0;
    int         ctl_age = 0, hi_len = 0, since_rise = 0, pidx = 0;
    bit         seen_rise = 1'b0;

    // Monitor and display model.
    always @(negedge clk) begin
        if (rst_n) begin
            item_t it;
            logic [7:0] exp_db;
            it = (exp_q.size() > 0) ? exp_q[0] : '0;
            if ((lcd_rs != prs) || (lcd_rw != prw)) ctl_age = 0;
            else ctl_age++;
            since_rise++;
            if (lcd_e && !e_prev) begin
                check(ctl_age >= EXP_AS, "R2 setup cycles", ctl_age, EXP_AS);
                if (seen_rise)
                    check(since_rise >= EXP_CYC, "R4 rise spacing", since_rise, EXP_CYC);
                seen_rise  = 1'b1;
                since_rise = 0;
                hi_len     = 1;
            end else if (lcd_e) begin
                hi_len++;
            end
            if (lcd_e) check(!req_ready, "R9 ready while busy", req_ready, 0);
            // Display model: returns valid data only after the read delay.
            if (lcd_e && lcd_rw) begin
                if (hi_len >= EXP_RDV)
                    lcd_db_in = it.m4 ? ((pidx == 0) ? {it.rb[7:4], 4'hC} : {it.rb[3:0], 4'hC})
                                      : it.rb;
                else
                    lcd_db_in = 8'hA5;
            end else begin
                lcd_db_in = 8'h3C;
            end
            if (!lcd_e && e_prev) begin
                check(hi_len >= EXP_PW, "R3 enable width", hi_len, EXP_PW);
                check(lcd_rs == prs && lcd_rw == prw && lcd_db_oe == poe && lcd_db_out == pdb,
                      "R5 hold at fall", {lcd_rs, lcd_rw, lcd_db_oe}, {prs, prw, poe});
                check(lcd_rs == it.rs, "R6 register select", lcd_rs, it.rs);
                if (it.rd) begin
                    check(lcd_rw && !lcd_db_oe, "R7 read direction", {lcd_rw, lcd_db_oe}, 2'b10);
                end else begin
                    check(!lcd_rw && lcd_db_oe, "R6 write direction", {lcd_rw, lcd_db_oe}, 2'b01);
                    exp_db = it.m4 ? ((pidx == 0) ? {it.wb[7:4], 4'h0} : {it.wb[3:0], 4'h0})
                                   : it.wb;
                    check(lcd_db_out == exp_db, it.m4 ? "R8 nibble lanes" : "R6 write byte",
                          lcd_db_out, exp_db);
                end
                pidx++;
            end
            if (done) begin
                check(req_ready, "R9 ready with done", req_ready, 1);
                check(pidx == (it.m4 ? 2 : 1), "R10 pulses per byte", pidx, it.m4 ? 2 : 1);
                if (it.rd)
                    check(done_rdata == it.rb, it.m4 ? "R8 nibble read" : "R7 read byte",
                          done_rdata, it.rb);
                if (exp_q.size() > 0) void'(exp_q.pop_front());
                pidx = 0;
            end
            prs    = lcd_rs;
            prw    = lcd_rw;
            poe    = lcd_db_oe;
            pdb    = lcd_db_out;
            e_prev = lcd_e;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired, queue=%0d expected=0", exp_q.size());
        finish_run();
    end

    // Stimulus.
    initial begin
        repeat (5) @(negedge clk);
        check(!lcd_e && !lcd_db_oe && !lcd_rw, "R1 bus idle in reset",
              {lcd_e, lcd_db_oe, lcd_rw}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!lcd_e && !lcd_db_oe && !lcd_rw, "R1 bus idle after reset",
              {lcd_e, lcd_db_oe, lcd_rw}, 0);
        check(req_ready && !done, "R1 handshake after reset", {req_ready, done}, 2'b10);

        send(1'b1, 1'b0, 1'b0, 8'hA7, 8'h00);
        send(1'b0, 1'b1, 1'b0, 8'h00, 8'h96);
        send(1'b1, 1'b0, 1'b1, 8'h3E, 8'h00);
        send(1'b0, 1'b1, 1'b1, 8'h00, 8'hD2);
        wait (exp_q.size() == 0);
        repeat (20) @(negedge clk);
        check(req_ready && !lcd_e, "R9 idle after drain", {req_ready, lcd_e}, 2'b10);
        send(1'b1, 1'b1, 1'b0, 8'h00, 8'h5B);
        send(1'b0, 1'b0, 1'b1, 8'hC4, 8'h00);
        send(1'b1, 1'b1, 1'b1, 8'h00, 8'h81);
        send(1'b0, 1'b0, 1'b0, 8'hFF, 8'h00);
        wait (exp_q.size() == 0);
        repeat (5) @(negedge clk);
        check(!lcd_db_oe && !lcd_rw, "R7 bus released at end", {lcd_db_oe, lcd_rw}, 0);
        finish_run();
    end

endmodule